// File: doc/BRIEF.md
# Runtime Bit-Field Manipulation Unit

This block performs field operations on a data word whose field position and length arrive as operands with every request rather than being fixed at build time. A request carries a destination word, a source word, a starting bit position, a field length and a 3-bit operation code. The block can zero a field in place or overwrite a field in place with the low bits of the source. It can also pull a field out of the source and right-align it, filling the upper bits with zeros or with copies of the field's top bit. As a separate mode, which ignores position and length, it computes destination AND NOT source.

A request whose field would run past the top of the word is rejected. A request with a zero length or an unused operation code is also rejected. In each of these cases the error output is raised and the destination is returned untouched. The word width is a parameter. A second parameter chooses between a registered result with a one-cycle valid and a purely combinational path.

Top module: `bfu_unit`

## Requirements
- R1: Operation code 0 (field clear) returns the destination with bits lsb through lsb+width-1 forced to zero and every other bit unchanged; for example, position 8 with length 12 zeroes bits 8 to 19.
- R2: Operation code 1 (field insert) returns the destination with bits lsb through lsb+width-1 replaced by source bits width-1 through 0; all other destination bits are kept.
- R3: Operation code 3 (unsigned extract) returns source bits lsb through lsb+width-1 moved down to bit 0, with every bit from width upward set to zero.
- R4: Operation code 2 (signed extract) returns the same right-aligned field as R3, but every bit from width upward is a copy of field bit width-1.
- R5: Operation code 4 returns destination AND NOT source, with no error flagged, whatever the position and length inputs hold.
- R6: A length equal to the word width acts as an all-ones mask, so with position 0 an insert returns the source and an extract returns the source (signed or unsigned alike).
- R7: A field operation with length 0 or with position plus length greater than the word width, and any request with operation code 5, 6 or 7, raises the error output and returns the destination unchanged.
- R8: With the registered variant, the result, error and valid of a request appear on the clock edge that captures the request; in a cycle without a request, valid is low on the next edge and the result and error outputs hold their previous values.
- R9: With the combinational variant, the result, error and valid follow the request inputs within the same cycle.
- R10: While reset is asserted (active low), the registered variant drives valid, result and error to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| op | input | 3 | Operation code: 0 clear, 1 insert, 2 signed extract, 3 unsigned extract, 4 and-not |
| lsb | input | $clog2(DW) | Lowest bit of the field |
| width | input | $clog2(DW+1) | Field length in bits, 1 to DW |
| dst | input | DW | Destination word |
| src | input | DW | Source word |
| out_valid | output | 1 | Result is valid |
| out_data | output | DW | Result word |
| out_err | output | 1 | Request rejected; out_data is the destination |

## Verification
The geometry check and the field operations are judged in the same cycle, because every request with a bad position/length pair still reaches the clear, insert or extract logic. The bench sweeps all eight operation codes against every position and every encodable length of an 8-bit instance, including lengths past the word width and the zero length. Each result is compared with a model that first decides rejection and only then applies the field arithmetic. The result must therefore be either the untouched destination with the error raised, or the correct field result with the error low, never a blend of the two.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

   typedef enum logic [2:0] {
      BFU_CLR  = 3'd0,
      BFU_INS  = 3'd1,
      BFU_SEXT = 3'd2,
      BFU_UEXT = 3'd3,
      BFU_ANDN = 3'd4
   } bfu_op_e;

   localparam int BFU_OP_W = 3;

endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
   parameter int DW    = 32,
   parameter int LSB_W = 5,
   parameter int WID_W = 6
) (
   input  logic [LSB_W-1:0] lsb_i,
   input  logic [WID_W-1:0] width_i,
   output logic [DW-1:0]    low_mask_o,
   output logic [DW-1:0]    field_mask_o,
   output logic [DW-1:0]    top_bit_o,
   output logic             geom_ok_o
);

   localparam int SUM_W = WID_W + 1;

   logic [SUM_W-1:0] span;

   assign span      = SUM_W'(lsb_i) + SUM_W'(width_i);
   assign geom_ok_o = (width_i != '0) && (span <= SUM_W'(DW));

   for (genvar g = 0; g < DW; g++) begin : g_bit
      assign low_mask_o[g]   = (WID_W'(g) < width_i);
      assign field_mask_o[g] = (SUM_W'(g) >= SUM_W'(lsb_i)) && (SUM_W'(g) < span);
      assign top_bit_o[g]    = (WID_W'(g + 1) == width_i);
   end

endmodule

// File: rtl/bfu_field_ops.sv
module bfu_field_ops
   import bfu_pkg::*;
#(
   parameter int DW    = 32,
   parameter int LSB_W = 5
) (
   input  logic [BFU_OP_W-1:0] op_i,
   input  logic [DW-1:0]       dst_i,
   input  logic [DW-1:0]       src_i,
   input  logic [LSB_W-1:0]    lsb_i,
   input  logic [DW-1:0]       low_mask_i,
   input  logic [DW-1:0]       field_mask_i,
   input  logic [DW-1:0]       top_bit_i,
   input  logic                geom_ok_i,
   output logic [DW-1:0]       result_o,
   output logic                err_o
);

   logic [DW-1:0] kept;
   logic [DW-1:0] placed;
   logic [DW-1:0] aligned;
   logic [DW-1:0] zext;
   logic [DW-1:0] sext;
   logic          sign_bit;
   logic [DW-1:0] raw;
   logic          need_geom;
   logic          bad_op;

   always_comb begin
      kept     = dst_i & ~field_mask_i;
      placed   = (src_i << lsb_i) & field_mask_i;
      aligned  = src_i >> lsb_i;
      zext     = aligned & low_mask_i;
      sign_bit = |(aligned & top_bit_i);
      sext     = zext | ({DW{sign_bit}} & ~low_mask_i);

      raw       = dst_i;
      need_geom = 1'b1;
      bad_op    = 1'b0;
      case (op_i)
         BFU_CLR:  raw = kept;
         BFU_INS:  raw = kept | placed;
         BFU_SEXT: raw = sext;
         BFU_UEXT: raw = zext;
         BFU_ANDN: begin
            raw       = dst_i & ~src_i;
            need_geom = 1'b0;
         end
         default:  bad_op = 1'b1;
      endcase

      err_o    = bad_op | (need_geom & ~geom_ok_i);
      result_o = err_o ? dst_i : raw;
   end

endmodule

// File: rtl/bfu_out_stage.sv
module bfu_out_stage #(
   parameter int DW      = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] res_i,
   input  logic          err_i,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_err
);

   if (REG_OUT) begin : g_reg
      logic          vld_q;
      logic [DW-1:0] data_q;
      logic          err_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
            err_q  <= 1'b0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) begin
               data_q <= res_i;
               err_q  <= err_i;
            end
         end
      end

      assign out_valid = vld_q;
      assign out_data  = data_q;
      assign out_err   = err_q;
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_data  = res_i;
      assign out_err   = err_i;
   end

endmodule

// File: rtl/bfu_unit.sv
module bfu_unit
   import bfu_pkg::*;
#(
   parameter  int DW      = 32,
   parameter  bit REG_OUT = 1'b1,
   localparam int LSB_W   = $clog2(DW),
   localparam int WID_W   = $clog2(DW + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [BFU_OP_W-1:0] op,
   input  logic [LSB_W-1:0]    lsb,
   input  logic [WID_W-1:0]    width,
   input  logic [DW-1:0]       dst,
   input  logic [DW-1:0]       src,
   output logic                out_valid,
   output logic [DW-1:0]       out_data,
   output logic                out_err
);

   if (DW < 2) begin : g_bad_dw
      $error("bfu_unit: DW must be at least 2");
   end

   logic [DW-1:0] low_mask;
   logic [DW-1:0] field_mask;
   logic [DW-1:0] top_bit;
   logic          geom_ok;
   logic [DW-1:0] result;
   logic          err;

   bfu_mask_gen #(.DW(DW), .LSB_W(LSB_W), .WID_W(WID_W)) u_mask (
      .lsb_i       (lsb),
      .width_i     (width),
      .low_mask_o  (low_mask),
      .field_mask_o(field_mask),
      .top_bit_o   (top_bit),
      .geom_ok_o   (geom_ok)
   );

   bfu_field_ops #(.DW(DW), .LSB_W(LSB_W)) u_ops (
      .op_i        (op),
      .dst_i       (dst),
      .src_i       (src),
      .lsb_i       (lsb),
      .low_mask_i  (low_mask),
      .field_mask_i(field_mask),
      .top_bit_i   (top_bit),
      .geom_ok_i   (geom_ok),
      .result_o    (result),
      .err_o       (err)
   );

   bfu_out_stage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .res_i    (result),
      .err_i    (err),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_err  (out_err)
   );

endmodule

// File: rtl/bfu_unit_chk.sv
module bfu_unit_chk #(
   parameter  int DW      = 32,
   parameter  bit REG_OUT = 1'b1,
   localparam int LSB_W   = $clog2(DW),
   localparam int WID_W   = $clog2(DW + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [2:0]       op,
   input logic [LSB_W-1:0] lsb,
   input logic [WID_W-1:0] width,
   input logic [DW-1:0]    dst,
   input logic [DW-1:0]    src,
   input logic             out_valid,
   input logic [DW-1:0]    out_data,
   input logic             out_err
);

   if (REG_OUT) begin : g_reg_props
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid); // R8
      AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid); // R8
      AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(out_data) && $stable(out_err))); // R8
      AST_BAD_OP_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op > 3'd4) |=> (out_err && out_data == $past(dst))); // R7
      AST_ANDN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 3'd4) |=> (!out_err && out_data == ($past(dst) & ~$past(src)))); // R5
      AST_CLEAR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 3'd0) |=> ((out_data & ~$past(dst)) == '0)); // R1
   end else begin : g_comb_props
      AST_COMB_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid); // R9
      AST_COMB_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
         (op > 3'd4) |-> (out_err && out_data == dst)); // R7
   end

endmodule

bind bfu_unit bfu_unit_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/bfu_unit_bench.sv
`timescale 1ns/1ps
module bfu_unit_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // 8-bit registered instance
   logic       s_in_valid = 1'b0;
   logic [2:0] s_op = '0;
   logic [2:0] s_lsb = '0;
   logic [3:0] s_width = '0;
   logic [7:0] s_dst = '0;
   logic [7:0] s_src = '0;
   logic       s_out_valid;
   logic [7:0] s_out_data;
   logic       s_out_err;

   bfu_unit #(.DW(8), .REG_OUT(1'b1)) u_bfu_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .op(s_op),
      .lsb(s_lsb), .width(s_width), .dst(s_dst), .src(s_src),
      .out_valid(s_out_valid), .out_data(s_out_data), .out_err(s_out_err)
   );

   // 32-bit combinational instance
   logic        w_in_valid = 1'b0;
   logic [2:0]  w_op = '0;
   logic [4:0]  w_lsb = '0;
   logic [5:0]  w_width = '0;
   logic [31:0] w_dst = '0;
   logic [31:0] w_src = '0;
   logic        w_out_valid;
   logic [31:0] w_out_data;
   logic        w_out_err;

   bfu_unit #(.DW(32), .REG_OUT(1'b0)) u_bfu_unit_w32 (
      .clk(clk), .rst_n(rst_n), .in_valid(w_in_valid), .op(w_op),
      .lsb(w_lsb), .width(w_width), .dst(w_dst), .src(w_src),
      .out_valid(w_out_valid), .out_data(w_out_data), .out_err(w_out_err)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Arithmetic reference for the 8-bit instance
   task automatic model8(input int op, input int l, input int w, input int d, input int s,
                         output int r, output int e, output string tag);
      int low, mask, f;
      e = 0;
      if (op > 4 || (op != 4 && (w == 0 || l + w > 8))) begin
         r = d; e = 1; tag = "R7"; return;
      end
      low  = (w >= 8) ? 255 : ((1 << w) - 1);
      mask = (low << l) & 255;
      case (op)
         0: begin r = d & ~mask & 255; tag = "R1"; end
         1: begin r = ((d & ~mask) | ((s << l) & mask)) & 255; tag = "R2"; end
         2: begin
            f = (s >> l) & low;
            if (f >= (1 << (w - 1))) f = f - (1 << w);
            r = f & 255; tag = "R4";
         end
         3: begin r = (s >> l) & low; tag = "R3"; end
         default: begin r = d & ~s & 255; tag = "R5"; end
      endcase
      if (op != 4 && w == 8) tag = "R6";
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      int d_tab[4];
      int s_tab[4];
      int exp_r, exp_e;
      string tag;
      logic [7:0] held;
      d_tab = '{8'hA5, 8'hFF, 8'h00, 8'h5A};
      s_tab = '{8'h3C, 8'h96, 8'h7F, 8'hE1};

      // R10: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R10 valid", s_out_valid, 0);
      check("R10 data", s_out_data, 0);
      check("R10 err", s_out_err, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Exhaustive sweep on 8-bit registered instance
      for (int op = 0; op < 8; op++) begin
         for (int l = 0; l < 8; l++) begin
            for (int w = 0; w < 16; w++) begin
               for (int p = 0; p < 4; p++) begin
                  @(negedge clk);
                  s_in_valid = 1'b1;
                  s_op = 3'(op); s_lsb = 3'(l); s_width = 4'(w);
                  s_dst = 8'(d_tab[p]); s_src = 8'(s_tab[(p + l) % 4]);
                  model8(op, l, w, d_tab[p], s_tab[(p + l) % 4], exp_r, exp_e, tag);
                  @(posedge clk);
                  #1;
                  if (s_out_valid !== 1'b1 || s_out_data !== 8'(exp_r) || s_out_err !== 1'(exp_e)) begin
                     check({tag, " R8"}, {s_out_valid, s_out_err, s_out_data},
                           {1'b1, 1'(exp_e), 8'(exp_r)});
                  end else begin
                     n_checks++;
                  end
               end
            end
         end
      end

      // R8: idle cycles hold result and error, valid drops
      held = s_out_data;
      @(negedge clk);
      s_in_valid = 1'b0;
      s_op = 3'd1; s_dst = 8'h12; s_src = 8'h34; s_lsb = 3'd0; s_width = 4'd8;
      @(posedge clk); #1;
      check("R8 valid low", s_out_valid, 0);
      check("R8 data hold", s_out_data, held);
      @(posedge clk); #1;
      check("R8 data hold 2", s_out_data, held);

      // R9 and 32-bit directed cases on the combinational instance
      w_in_valid = 1'b1;
      w_op = 3'd0; w_lsb = 5'd8; w_width = 6'd12; w_dst = 32'hFFFF_FFFF; w_src = 32'h0;
      #1;
      check("R9 valid", w_out_valid, 1);
      check("R1 clear 8/12", w_out_data, 32'hFFF0_00FF);
      check("R1 err", w_out_err, 0);
      w_op = 3'd1; w_dst = 32'h1111_1111; w_src = 32'hABCD_E123;
      #1;
      check("R2 insert 8/12", w_out_data, 32'h1111_2311);
      w_op = 3'd1; w_lsb = 5'd0; w_width = 6'd32; w_dst = 32'h0; w_src = 32'hDEAD_BEEF;
      #1;
      check("R6 insert full", w_out_data, 32'hDEAD_BEEF);
      w_op = 3'd2; w_src = 32'h8000_0001;
      #1;
      check("R6 sext full", w_out_data, 32'h8000_0001);
      w_op = 3'd2; w_lsb = 5'd28; w_width = 6'd4; w_src = 32'h8000_0000;
      #1;
      check("R4 sext top nibble", w_out_data, 32'hFFFF_FFF8);
      w_op = 3'd3;
      #1;
      check("R3 uext top nibble", w_out_data, 32'h0000_0008);
      w_op = 3'd3; w_lsb = 5'd12; w_width = 6'd8; w_src = 32'h1234_5678;
      #1;
      check("R3 uext mid", w_out_data, 32'h0000_0045);
      w_op = 3'd1; w_lsb = 5'd1; w_width = 6'd32; w_dst = 32'hCAFE_F00D;
      #1;
      check("R7 overrun err", w_out_err, 1);
      check("R7 overrun data", w_out_data, 32'hCAFE_F00D);
      w_op = 3'd4; w_dst = 32'hF0F0_FFFF; w_src = 32'h00FF_000F;
      #1;
      check("R5 andnot", w_out_data, 32'hF000_FFF0);
      check("R5 no err", w_out_err, 0);
      w_in_valid = 1'b0;
      #1;
      check("R9 valid low", w_out_valid, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule